// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clock domains of a small 8-bit microcontroller run at any moment. It follows three operating levels, a full-speed run level, a light sleep (HALT) and a deep sleep (STOP). It also has an internal recovery phase that sits between deep sleep and run. The CPU delivers decoded one-cycle strobes for its HALT and STOP instructions. The surrounding logic supplies an enabled-interrupt wake strobe, a stop-mode recovery strobe, three configuration bits and one enable bit per peripheral.

The block turns the current level into registered enables. These cover the main crystal oscillator, the internal precision oscillator, the system clock, the CPU clock, the program-counter advance, the watchdog oscillator, the watchdog logic, the brown-out monitor, a peripheral-idle indication and one gated clock enable per peripheral.

In deep sleep only the watchdog oscillator, the watchdog logic and the brown-out monitor may stay alive, each under its own configuration bit. When a recovery event arrives, the oscillators start first. The system and CPU clocks are released only after a parameterised stabilisation count. Every output is a flop whose value is decoded from the next state, so each enable changes on a clock edge and never glitches.

Top module: `lpm_clkctl`

## Requirements
- R1: While `rst_n` is low the controller is in run level: `osc_main_en`, `osc_ipo_en`, `sysclk_en`, `cpuclk_en`, `pc_adv_en` and `bo_mon_en` are 1, and `wdt_osc_en`, `wdt_run_en`, `periph_idle` and all `periph_clk_en` bits are 0.
- R2: In run level, one cycle after its inputs are sampled:
  - `periph_clk_en[i]` equals `periph_en[i]` for each peripheral bit i.
  - `wdt_osc_en` equals `cfg_wdt_osc_en`.
  - `wdt_run_en` equals `cfg_wdt_en`.
  - `periph_idle` is 0.
- R3: A `halt_req` pulse in run level enters light sleep on the next edge. In light sleep `cpuclk_en` and `pc_adv_en` are 0, while both oscillator enables and `sysclk_en` stay 1 and `periph_clk_en` still follows `periph_en`.
- R4: In light sleep, a `wake_irq` or `smr_event` pulse returns the controller to run level on the next edge.
- R5: A `stop_req` pulse in run level enters deep sleep on the next edge. When `stop_req` and `halt_req` arrive together, deep sleep wins.
- R6: In deep sleep the following are all 0: `osc_main_en`, `osc_ipo_en`, `sysclk_en`, `cpuclk_en`, `pc_adv_en` and every `periph_clk_en` bit. `periph_idle` is 1.
- R7: In deep sleep, `wdt_osc_en` follows `cfg_wdt_osc_en`, `wdt_run_en` follows `cfg_wdt_en`, and `bo_mon_en` follows `cfg_bo_in_stop`. Outside deep sleep `bo_mon_en` is 1.
- R8: Deep sleep is left only on `smr_event`. Pulses on `wake_irq`, `halt_req` and `stop_req` leave all outputs at their deep-sleep values.
- R9: After `smr_event` in deep sleep, the recovery phase begins on the next edge.
  - From that edge, both oscillator enables are 1.
  - For STAB_CYC cycles, `sysclk_en`, `cpuclk_en`, `pc_adv_en` and `periph_clk_en` stay 0 and `periph_idle` stays 1.
  - On the following edge all run-level enables return.
- R10: The system clock never runs without both oscillators, and the CPU clock never runs without the system clock.
- R11: Strobes with no meaning in the current level are ignored: `smr_event` in run level, and `stop_req`/`halt_req` during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Decoded STOP instruction strobe |
| halt_req | input | 1 | Decoded HALT instruction strobe |
| wake_irq | input | 1 | Enabled interrupt pending, wakes light sleep |
| smr_event | input | 1 | Stop-mode recovery event |
| cfg_wdt_osc_en | input | 1 | Watchdog oscillator enable bit |
| cfg_wdt_en | input | 1 | Watchdog logic enable bit |
| cfg_bo_in_stop | input | 1 | Nonvolatile option: brown-out monitor kept in deep sleep |
| periph_en | input | N_PERIPH | Per-peripheral enable bits |
| osc_main_en | output | 1 | Primary crystal oscillator enable |
| osc_ipo_en | output | 1 | Internal precision oscillator enable |
| sysclk_en | output | 1 | System clock enable |
| cpuclk_en | output | 1 | CPU clock enable |
| pc_adv_en | output | 1 | Program-counter advance enable |
| wdt_osc_en | output | 1 | Watchdog RC oscillator enable |
| wdt_run_en | output | 1 | Watchdog logic enable |
| bo_mon_en | output | 1 | Brown-out monitor enable |
| periph_idle | output | 1 | Idle indication to peripherals |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |

## Verification
The hardest situation to reach is the recovery phase. The bench must first enter deep sleep and then see `smr_event`, and ignored strobes can arrive during the stabilisation count only in that window. The bench gets there with a per-configuration loop. Each pass enters deep sleep with both instruction strobes raised together and fires every ignored strobe while asleep. It then recovers, injects a stray `stop_req` in the middle of the count, and samples the last cycle of the count and the first run-level cycle after it. Across the loop, all eight combinations of the three keep-alive bits are checked in deep sleep, and all sixteen peripheral enable patterns are swept in run level and light sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LVL_RUN   = 2'd0,
    LVL_LIGHT = 2'd1,
    LVL_DEEP  = 2'd2,
    LVL_RECOV = 2'd3
  } lvl_e;

  typedef struct packed {
    logic osc_main;
    logic osc_ipo;
    logic sysclk;
    logic cpuclk;
    logic pc_adv;
    logic bo_mon;
    logic idle;
    logic pclk_gate;
  } dom_en_t;

  function automatic dom_en_t level_domains(input lvl_e lvl, input logic bo_keep);
    dom_en_t d;
    d.osc_main  = (lvl != LVL_DEEP);
    d.osc_ipo   = (lvl != LVL_DEEP);
    d.sysclk    = (lvl == LVL_RUN) || (lvl == LVL_LIGHT);
    d.cpuclk    = (lvl == LVL_RUN);
    d.pc_adv    = (lvl == LVL_RUN);
    d.bo_mon    = (lvl == LVL_DEEP) ? bo_keep : 1'b1;
    d.idle      = (lvl == LVL_DEEP) || (lvl == LVL_RECOV);
    d.pclk_gate = (lvl == LVL_RUN) || (lvl == LVL_LIGHT);
    return d;
  endfunction

endpackage

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
  parameter int unsigned STAB_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (STAB_CYC < 2) ? 1 : $clog2(STAB_CYC);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run && (cnt_q != LAST)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic halt_req,
  input  logic wake_irq,
  input  logic smr_event,
  input  logic stab_done,
  output lvl_e lvl_q,
  output lvl_e lvl_d
);

  always_comb begin
    lvl_d = lvl_q;
    unique case (lvl_q)
      LVL_RUN: begin
        if (stop_req)      lvl_d = LVL_DEEP;
        else if (halt_req) lvl_d = LVL_LIGHT;
      end
      LVL_LIGHT: begin
        if (wake_irq || smr_event) lvl_d = LVL_RUN;
      end
      LVL_DEEP: begin
        if (smr_event) lvl_d = LVL_RECOV;
      end
      LVL_RECOV: begin
        if (stab_done) lvl_d = LVL_RUN;
      end
      default: lvl_d = LVL_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= LVL_RUN;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/lpm_enable_reg.sv
module lpm_enable_reg
  import lpm_pkg::*;
#(
  parameter int unsigned N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lvl_e                lvl_d,
  input  logic                cfg_wdt_osc_en,
  input  logic                cfg_wdt_en,
  input  logic                cfg_bo_in_stop,
  input  logic [N_PERIPH-1:0] periph_en,
  output dom_en_t             dom_q,
  output logic                wdt_osc_q,
  output logic                wdt_run_q,
  output logic [N_PERIPH-1:0] pclk_q
);
  localparam dom_en_t DOM_RST = '{osc_main: 1'b1, osc_ipo: 1'b1, sysclk: 1'b1,
                                  cpuclk: 1'b1, pc_adv: 1'b1, bo_mon: 1'b1,
                                  idle: 1'b0, pclk_gate: 1'b0};

  dom_en_t dom_d;

  always_comb dom_d = level_domains(lvl_d, cfg_bo_in_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q     <= DOM_RST;
      wdt_osc_q <= 1'b0;
      wdt_run_q <= 1'b0;
    end else begin
      dom_q     <= dom_d;
      wdt_osc_q <= cfg_wdt_osc_en;
      wdt_run_q <= cfg_wdt_en;
    end
  end

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_pclk
    logic pclk_d;
    always_comb pclk_d = dom_d.pclk_gate & periph_en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pclk_q[i] <= 1'b0;
      else        pclk_q[i] <= pclk_d;
    end
  end
endmodule

// File: rtl/lpm_clkctl.sv
module lpm_clkctl
  import lpm_pkg::*;
#(
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned STAB_CYC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                halt_req,
  input  logic                wake_irq,
  input  logic                smr_event,
  input  logic                cfg_wdt_osc_en,
  input  logic                cfg_wdt_en,
  input  logic                cfg_bo_in_stop,
  input  logic [N_PERIPH-1:0] periph_en,
  output logic                osc_main_en,
  output logic                osc_ipo_en,
  output logic                sysclk_en,
  output logic                cpuclk_en,
  output logic                pc_adv_en,
  output logic                wdt_osc_en,
  output logic                wdt_run_en,
  output logic                bo_mon_en,
  output logic                periph_idle,
  output logic [N_PERIPH-1:0] periph_clk_en
);
  lvl_e    lvl_q, lvl_d;
  logic    stab_done;
  dom_en_t dom_q;

  lpm_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .halt_req  (halt_req),
    .wake_irq  (wake_irq),
    .smr_event (smr_event),
    .stab_done (stab_done),
    .lvl_q     (lvl_q),
    .lvl_d     (lvl_d)
  );

  lpm_stab_cnt #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (lvl_q == LVL_RECOV),
    .done  (stab_done)
  );

  lpm_enable_reg #(.N_PERIPH(N_PERIPH)) u_en (
    .clk            (clk),
    .rst_n          (rst_n),
    .lvl_d          (lvl_d),
    .cfg_wdt_osc_en (cfg_wdt_osc_en),
    .cfg_wdt_en     (cfg_wdt_en),
    .cfg_bo_in_stop (cfg_bo_in_stop),
    .periph_en      (periph_en),
    .dom_q          (dom_q),
    .wdt_osc_q      (wdt_osc_en),
    .wdt_run_q      (wdt_run_en),
    .pclk_q         (periph_clk_en)
  );

  assign osc_main_en = dom_q.osc_main;
  assign osc_ipo_en  = dom_q.osc_ipo;
  assign sysclk_en   = dom_q.sysclk;
  assign cpuclk_en   = dom_q.cpuclk;
  assign pc_adv_en   = dom_q.pc_adv;
  assign bo_mon_en   = dom_q.bo_mon;
  assign periph_idle = dom_q.idle;
endmodule

// File: rtl/lpm_clkctl_chk.sv
module lpm_clkctl_chk #(
  parameter int unsigned N_PERIPH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smr_event,
  input logic                osc_main_en,
  input logic                osc_ipo_en,
  input logic                sysclk_en,
  input logic                cpuclk_en,
  input logic                pc_adv_en,
  input logic                periph_idle,
  input logic [N_PERIPH-1:0] periph_clk_en
);
  // R10
  sys_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysclk_en |-> (osc_main_en && osc_ipo_en));

  // R10
  cpu_needs_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuclk_en || pc_adv_en) |-> sysclk_en);

  // R6
  idle_gates_pclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_idle |-> (periph_clk_en == '0));

  // R6
  osc_off_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_main_en) |-> (!sysclk_en && !cpuclk_en && !osc_ipo_en));

  // R8
  deep_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_main_en && !smr_event) |=> !osc_main_en);

  // R9
  osc_before_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_en) |-> $past(osc_main_en && osc_ipo_en));
endmodule

bind lpm_clkctl lpm_clkctl_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .smr_event     (smr_event),
  .osc_main_en   (osc_main_en),
  .osc_ipo_en    (osc_ipo_en),
  .sysclk_en     (sysclk_en),
  .cpuclk_en     (cpuclk_en),
  .pc_adv_en     (pc_adv_en),
  .periph_idle   (periph_idle),
  .periph_clk_en (periph_clk_en)
);

// File: tb/lpm_clkctl_tb.sv
`timescale 1ns/1ps
module lpm_clkctl_tb;
  localparam int NP = 4;
  localparam int SC = 6;
  localparam int M_RUN = 0, M_LIGHT = 1, M_DEEP = 2, M_RECOV = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic stop_req, halt_req, wake_irq, smr_event;
  logic cfg_wdt_osc_en, cfg_wdt_en, cfg_bo_in_stop;
  logic [NP-1:0] periph_en;
  logic osc_main_en, osc_ipo_en, sysclk_en, cpuclk_en, pc_adv_en;
  logic wdt_osc_en, wdt_run_en, bo_mon_en, periph_idle;
  logic [NP-1:0] periph_clk_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpm_clkctl #(.N_PERIPH(NP), .STAB_CYC(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .halt_req(halt_req),
    .wake_irq(wake_irq), .smr_event(smr_event), .cfg_wdt_osc_en(cfg_wdt_osc_en),
    .cfg_wdt_en(cfg_wdt_en), .cfg_bo_in_stop(cfg_bo_in_stop), .periph_en(periph_en),
    .osc_main_en(osc_main_en), .osc_ipo_en(osc_ipo_en), .sysclk_en(sysclk_en),
    .cpuclk_en(cpuclk_en), .pc_adv_en(pc_adv_en), .wdt_osc_en(wdt_osc_en),
    .wdt_run_en(wdt_run_en), .bo_mon_en(bo_mon_en), .periph_idle(periph_idle),
    .periph_clk_en(periph_clk_en)
  );

  function automatic logic [12:0] obs();
    return {osc_main_en, osc_ipo_en, sysclk_en, cpuclk_en, pc_adv_en,
            wdt_osc_en, wdt_run_en, bo_mon_en, periph_idle, periph_clk_en};
  endfunction

  function automatic logic [12:0] expect_of(int m, logic [2:0] cfg, logic [NP-1:0] pe);
    logic on_osc, sys, cpu, bo, idle;
    logic [NP-1:0] pc;
    on_osc = (m != M_DEEP);
    sys    = (m == M_RUN) || (m == M_LIGHT);
    cpu    = (m == M_RUN);
    bo     = (m == M_DEEP) ? cfg[0] : 1'b1;
    idle   = (m == M_DEEP) || (m == M_RECOV);
    pc     = sys ? pe : '0;
    return {on_osc, on_osc, sys, cpu, cpu, cfg[2], cfg[1], bo, idle, pc};
  endfunction

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] cfg);
    {cfg_wdt_osc_en, cfg_wdt_en, cfg_bo_in_stop} = cfg;
  endtask

  task automatic pulse(input logic s, input logic h, input logic w, input logic r);
    stop_req = s; halt_req = h; wake_irq = w; smr_event = r;
    @(negedge clk);
    stop_req = 0; halt_req = 0; wake_irq = 0; smr_event = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    stop_req = 0; halt_req = 0; wake_irq = 0; smr_event = 0;
    set_cfg(3'b111); periph_en = '1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 reset", obs(), {5'b11111, 3'b001, 1'b0, {NP{1'b0}}});
    rst_n = 1;

    // R2 R10: run level sweep of configuration and enables
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < (1 << NP); p++) begin
        set_cfg(3'(c)); periph_en = NP'(p);
        @(negedge clk);
        chk("R2 run sweep", obs(), expect_of(M_RUN, 3'(c), NP'(p)));
      end
    end

    // R11: recovery strobe in run level ignored
    set_cfg(3'b010); periph_en = 4'b1010;
    pulse(0, 0, 0, 1);
    chk("R11 smr in run", obs(), expect_of(M_RUN, 3'b010, 4'b1010));

    // R3: light sleep with enable sweep
    pulse(0, 1, 0, 0);
    chk("R3 light entry", obs(), expect_of(M_LIGHT, 3'b010, 4'b1010));
    for (int p = 0; p < (1 << NP); p++) begin
      periph_en = NP'(p);
      @(negedge clk);
      chk("R3 light sweep", obs(), expect_of(M_LIGHT, 3'b010, NP'(p)));
    end
    // R4: wake by interrupt
    pulse(0, 0, 1, 0);
    chk("R4 light exit irq", obs(), expect_of(M_RUN, 3'b010, periph_en));
    // R4: wake by recovery event
    pulse(0, 1, 0, 0);
    chk("R3 light re-entry", obs(), expect_of(M_LIGHT, 3'b010, periph_en));
    pulse(0, 0, 0, 1);
    chk("R4 light exit smr", obs(), expect_of(M_RUN, 3'b010, periph_en));

    // R5 R6 R7 R8 R9 R11: deep sleep per configuration
    for (int c = 0; c < 8; c++) begin
      set_cfg(3'(c)); periph_en = NP'(c * 2 + 1);
      pulse(1, 1, 0, 0);
      chk("R5 deep entry wins over halt", obs(), expect_of(M_DEEP, 3'(c), periph_en));
      periph_en = ~periph_en;
      @(negedge clk);
      chk("R6 R7 deep outputs", obs(), expect_of(M_DEEP, 3'(c), periph_en));
      pulse(0, 0, 1, 0);
      chk("R8 irq ignored in deep", obs(), expect_of(M_DEEP, 3'(c), periph_en));
      pulse(0, 1, 0, 0);
      chk("R8 halt ignored in deep", obs(), expect_of(M_DEEP, 3'(c), periph_en));
      pulse(1, 0, 0, 0);
      chk("R8 stop ignored in deep", obs(), expect_of(M_DEEP, 3'(c), periph_en));
      pulse(0, 0, 0, 1);
      chk("R9 recovery first cycle", obs(), expect_of(M_RECOV, 3'(c), periph_en));
      pulse(1, 1, 0, 0);
      chk("R11 strobes ignored in recovery", obs(), expect_of(M_RECOV, 3'(c), periph_en));
      repeat (SC - 2) @(negedge clk);
      chk("R9 recovery last cycle", obs(), expect_of(M_RECOV, 3'(c), periph_en));
      @(negedge clk);
      chk("R9 run after count", obs(), expect_of(M_RUN, 3'(c), periph_en));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule